// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block decodes the bus-write cycles aimed at a boot-block NOR flash with a 16-bit data bus. It groups one, two or three writes into commands. Some commands only pick what later bus reads return: array data, status byte, identification code or query data. Others start a word program, a paired-word program or a block erase on an internal program/erase engine. The engine is modelled as a cycle-count timer, so busy, completion and suspend timing are exact and repeatable.

The set of commands the block accepts depends on the engine state. While the engine runs, almost every write is dropped, and every read returns the status byte. A running operation can be paused. While an erase is paused, a word program may be run inside it, and the erase then goes back to its paused state. Each accepted operation raises one issue strobe, together with its address and data, for the array-side logic. An active-low reset stops any operation and restores read-array mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read selector is array (rd_mode 0), the engine is idle, and the status byte reads 80h. Status byte bits: bit 7 ready, bit 6 erase paused, bit 5 erase error, bit 4 program error, bit 2 program paused, all other bits 0.
- R2: With the engine idle and nothing paused, a single write selects the read source: FFh selects array (rd_mode 0, rd_data = arr_data), 70h selects status (1), 90h selects identification (2), 98h selects query (3, rd_data = qry_data). 50h clears status bits 5 and 4 and leaves rd_mode unchanged. Any other single write that does not open a sequence (20h, 40h, 30h) returns rd_mode to 0.
- R3: In identification mode, rd_lsb low reads {00h, MFR_CODE} and rd_lsb high reads {00h, DEV_CODE}.
- R4: Word program is the write 40h followed by a write of address and data. In the cycle after the second write, issue_word pulses for one cycle with that address in issue_addr and that data in issue_data0. eng_busy is then high for exactly WORD_CYCLES cycles.
- R5: Block erase is the write 20h followed by a write whose low data byte is D0h. That starts the erase: issue_erase pulses, and eng_busy is then high for ERASE_CYCLES cycles. Any other second byte starts nothing, sets status bits 5 and 4, and returns rd_mode to 0.
- R6: Paired program is the write 30h followed by two address/data writes. If the two addresses differ only in bit 0, issue_pair pulses with the first address in issue_addr, the first data in issue_data0 and the second data in issue_data1. Any other pair of addresses starts nothing, sets status bit 4, and returns rd_mode to 0.
- R7: While eng_busy is high, only 70h and B0h take effect. No other write changes the read source or starts anything. Reads return the status byte (rd_mode 1).
- R8: B0h written while an operation runs pauses it from the next cycle: eng_busy drops, and status bit 6 (erase) or bit 2 (program) is set. D0h written while paused clears that bit, resumes the count and selects status. The busy cycles of one operation add up to its full length in spite of the pause.
- R9: While paused, the block accepts D0h and the four read-select writes. It accepts 40h, with its data write, only when the paused operation is an erase. That nested program is busy for WORD_CYCLES cycles, after which the erase is paused again (status C0h). All other writes are dropped.
- R10: Pulling rst_n low during an operation stops it: eng_busy goes low, rd_mode returns to 0, and the status error bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, aborts any operation |
| wr_stb | input | 1 | One-cycle bus-write strobe |
| wr_addr | input | ADDR_W | Bus-write address |
| wr_data | input | DATA_W | Bus-write data; the low byte carries the command |
| rd_lsb | input | 1 | Lowest read-address bit, selects the identification code |
| arr_data | input | DATA_W | Array word for the current read address |
| qry_data | input | DATA_W | Query word for the current read address |
| rd_data | output | DATA_W | Bus-read data for the selected source |
| rd_mode | output | 2 | Read source in effect: 0 array, 1 status, 2 identification, 3 query |
| issue_word | output | 1 | Word program started (one cycle) |
| issue_pair | output | 1 | Paired program started (one cycle) |
| issue_erase | output | 1 | Block erase started (one cycle) |
| issue_addr | output | ADDR_W | Address of the started operation |
| issue_data0 | output | DATA_W | First data word of the started operation |
| issue_data1 | output | DATA_W | Second data word (paired program only) |
| eng_busy | output | 1 | Engine running and not paused |
| eng_done | output | 1 | One-cycle pulse when a run completes |

## Verification
The grammar is tried with directed sequences of each command, sent from an idle, a busy and a paused engine. This shows whether the block filters writes by engine state or decodes every write the same way. A paused erase hosting a nested program, and a paused program that rejects one, separate the two kinds of pause. Counting busy cycles across a pause shows whether the remaining count is kept. Bad erase confirms and mismatched paired addresses show that error flags are set without any strobe. A seeded random run of single-cycle opcodes is then checked against a bench model of the read-source selection. It catches opcodes that are decoded wrongly or silently dropped.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2,
      RM_QUERY  = 2'd3
   } rd_mode_e;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_WORD  = 2'd1,
      OPK_PAIR  = 2'd2,
      OPK_ERASE = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      SQ_IDLE        = 3'd0,
      SQ_ERS_CONFIRM = 3'd1,
      SQ_WORD_DATA   = 3'd2,
      SQ_PAIR_FIRST  = 3'd3,
      SQ_PAIR_SECOND = 3'd4
   } seq_state_e;

   // erase confirm byte, fixed by the command grammar
   localparam logic [7:0] ERASE_CONFIRM = 8'hD0;

   // status byte bit positions
   localparam int unsigned SB_READY   = 7;
   localparam int unsigned SB_ERS_SUS = 6;
   localparam int unsigned SB_ERS_ERR = 5;
   localparam int unsigned SB_PGM_ERR = 4;
   localparam int unsigned SB_PGM_SUS = 2;

   // all packed opcodes must be pairwise different
   function automatic bit fcs_ops_distinct(input logic [79:0] ops);
      for (int i = 0; i < 10; i++) begin
         for (int j = i + 1; j < 10; j++) begin
            if (ops[i*8 +: 8] == ops[j*8 +: 8]) return 1'b0;
         end
      end
      return 1'b1;
   endfunction

endpackage

// File: rtl/fcs_engine.sv
module fcs_engine
   import fcs_pkg::*;
#(
   parameter int unsigned WORD_CYCLES  = 12,
   parameter int unsigned ERASE_CYCLES = 40
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_vld,
   input  op_kind_e start_kind,
   input  logic     nest_vld,
   input  logic     susp_req,
   input  logic     resume_req,
   output logic     busy,
   output logic     susp_erase,
   output logic     susp_word,
   output logic     nested,
   output logic     done
);

   localparam int unsigned MAXC = (ERASE_CYCLES > WORD_CYCLES) ? ERASE_CYCLES : WORD_CYCLES;
   localparam int unsigned CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] WORD_LAST  = CW'(WORD_CYCLES - 1);
   localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYCLES - 1);

   logic            run_q;
   logic            susp_q;
   logic            nest_q;
   op_kind_e        kind_q;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   cnt_save_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         susp_q     <= 1'b0;
         nest_q     <= 1'b0;
         kind_q     <= OPK_NONE;
         cnt_q      <= '0;
         cnt_save_q <= '0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run_q) begin
            if (start_vld) begin
               run_q  <= 1'b1;
               kind_q <= start_kind;
               cnt_q  <= (start_kind == OPK_ERASE) ? ERASE_LAST : WORD_LAST;
            end
         end else if (susp_q) begin
            if (resume_req) begin
               susp_q <= 1'b0;
            end else if (nest_vld && kind_q == OPK_ERASE) begin
               cnt_save_q <= cnt_q;
               cnt_q      <= WORD_LAST;
               kind_q     <= OPK_WORD;
               susp_q     <= 1'b0;
               nest_q     <= 1'b1;
            end
         end else if (cnt_q == '0) begin
            // final cycle: completes even if a pause was asked for
            done <= 1'b1;
            if (nest_q) begin
               nest_q <= 1'b0;
               kind_q <= OPK_ERASE;
               cnt_q  <= cnt_save_q;
               susp_q <= 1'b1;
            end else begin
               run_q  <= 1'b0;
               kind_q <= OPK_NONE;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
            if (susp_req && !nest_q) susp_q <= 1'b1;
         end
      end
   end

   assign busy       = run_q && !susp_q;
   assign susp_erase = run_q && susp_q && (kind_q == OPK_ERASE);
   assign susp_word  = run_q && susp_q && (kind_q != OPK_ERASE);
   assign nested     = nest_q;

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= ERASE_LAST || cnt_q <= WORD_LAST));

   assert_nest_from_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nest_q) |-> $past(susp_erase));

   assert_done_idles_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_pause_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && susp_req && !nest_q && cnt_q != '0) |=> !busy);

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 19,
   parameter int unsigned DATA_W      = 16,
   parameter bit          PAIR_EN     = 1'b1,
   parameter logic [7:0]  OP_ARRAY    = 8'hFF,
   parameter logic [7:0]  OP_STATUS   = 8'h70,
   parameter logic [7:0]  OP_IDENT    = 8'h90,
   parameter logic [7:0]  OP_QUERY    = 8'h98,
   parameter logic [7:0]  OP_CLEAR    = 8'h50,
   parameter logic [7:0]  OP_ERASE    = 8'h20,
   parameter logic [7:0]  OP_WORD     = 8'h40,
   parameter logic [7:0]  OP_PAIR     = 8'h30,
   parameter logic [7:0]  OP_SUSPEND  = 8'hB0,
   parameter logic [7:0]  OP_RESUME   = 8'hD0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_busy,
   input  logic              eng_susp_erase,
   input  logic              eng_susp_word,
   input  logic              eng_nested,
   output rd_mode_e          mode,
   output logic              prog_err,
   output logic              erase_err,
   output logic              start_vld,
   output op_kind_e          start_kind,
   output logic              nest_vld,
   output logic              susp_req,
   output logic              resume_req,
   output logic              issue_word,
   output logic              issue_pair,
   output logic              issue_erase,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [DATA_W-1:0] issue_data0,
   output logic [DATA_W-1:0] issue_data1
);

   seq_state_e        state_q, state_n;
   rd_mode_e          mode_n;
   logic              perr_n, eerr_n;
   logic [ADDR_W-1:0] first_addr_q;
   logic [DATA_W-1:0] first_data_q;
   logic              pair_ok;
   logic              eng_susp;
   logic [7:0]        op;

   generate
      if (PAIR_EN) begin : g_pair_on
         assign pair_ok = 1'b1;
      end else begin : g_pair_off
         assign pair_ok = 1'b0;
      end
   endgenerate

   assign eng_susp = eng_susp_erase || eng_susp_word;
   assign op       = wr_data[7:0];

   always_comb begin
      state_n    = state_q;
      mode_n     = mode;
      perr_n     = prog_err;
      eerr_n     = erase_err;
      start_vld  = 1'b0;
      start_kind = OPK_NONE;
      nest_vld   = 1'b0;
      susp_req   = 1'b0;
      resume_req = 1'b0;
      if (wr_stb) begin
         case (state_q)
            SQ_IDLE: begin
               if (eng_busy) begin
                  if (op == OP_STATUS)                    mode_n   = RM_STATUS;
                  else if (op == OP_SUSPEND && !eng_nested) susp_req = 1'b1;
               end else if (eng_susp) begin
                  if (op == OP_RESUME) begin
                     resume_req = 1'b1;
                     mode_n     = RM_STATUS;
                  end
                  else if (op == OP_ARRAY)  mode_n = RM_ARRAY;
                  else if (op == OP_STATUS) mode_n = RM_STATUS;
                  else if (op == OP_IDENT)  mode_n = RM_IDENT;
                  else if (op == OP_QUERY)  mode_n = RM_QUERY;
                  else if (op == OP_WORD && eng_susp_erase) state_n = SQ_WORD_DATA;
               end else begin
                  if (op == OP_ARRAY)       mode_n = RM_ARRAY;
                  else if (op == OP_STATUS) mode_n = RM_STATUS;
                  else if (op == OP_IDENT)  mode_n = RM_IDENT;
                  else if (op == OP_QUERY)  mode_n = RM_QUERY;
                  else if (op == OP_CLEAR) begin
                     perr_n = 1'b0;
                     eerr_n = 1'b0;
                  end
                  else if (op == OP_ERASE)            state_n = SQ_ERS_CONFIRM;
                  else if (op == OP_WORD)             state_n = SQ_WORD_DATA;
                  else if (op == OP_PAIR && pair_ok)  state_n = SQ_PAIR_FIRST;
                  else                                mode_n  = RM_ARRAY;
               end
            end
            SQ_ERS_CONFIRM: begin
               state_n = SQ_IDLE;
               if (op == ERASE_CONFIRM) begin
                  start_vld  = 1'b1;
                  start_kind = OPK_ERASE;
                  mode_n     = RM_STATUS;
               end else begin
                  eerr_n = 1'b1;
                  perr_n = 1'b1;
                  mode_n = RM_ARRAY;
               end
            end
            SQ_WORD_DATA: begin
               state_n = SQ_IDLE;
               mode_n  = RM_STATUS;
               if (eng_susp) begin
                  nest_vld = 1'b1;
               end else begin
                  start_vld  = 1'b1;
                  start_kind = OPK_WORD;
               end
            end
            SQ_PAIR_FIRST: begin
               state_n = SQ_PAIR_SECOND;
            end
            SQ_PAIR_SECOND: begin
               state_n = SQ_IDLE;
               if (wr_addr[ADDR_W-1:1] == first_addr_q[ADDR_W-1:1] &&
                   wr_addr[0] != first_addr_q[0]) begin
                  start_vld  = 1'b1;
                  start_kind = OPK_PAIR;
                  mode_n     = RM_STATUS;
               end else begin
                  perr_n = 1'b1;
                  mode_n = RM_ARRAY;
               end
            end
            default: begin
               state_n = SQ_IDLE;
               mode_n  = RM_ARRAY;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= SQ_IDLE;
         mode         <= RM_ARRAY;
         prog_err     <= 1'b0;
         erase_err    <= 1'b0;
         first_addr_q <= '0;
         first_data_q <= '0;
         issue_word   <= 1'b0;
         issue_pair   <= 1'b0;
         issue_erase  <= 1'b0;
         issue_addr   <= '0;
         issue_data0  <= '0;
         issue_data1  <= '0;
      end else begin
         state_q   <= state_n;
         mode      <= mode_n;
         prog_err  <= perr_n;
         erase_err <= eerr_n;
         if (wr_stb && state_q == SQ_PAIR_FIRST) begin
            first_addr_q <= wr_addr;
            first_data_q <= wr_data;
         end
         issue_word  <= nest_vld || (start_vld && start_kind == OPK_WORD);
         issue_pair  <= start_vld && start_kind == OPK_PAIR;
         issue_erase <= start_vld && start_kind == OPK_ERASE;
         if (start_vld || nest_vld) begin
            if (start_kind == OPK_PAIR) begin
               issue_addr  <= first_addr_q;
               issue_data0 <= first_data_q;
               issue_data1 <= wr_data;
            end else begin
               issue_addr  <= wr_addr;
               issue_data0 <= wr_data;
               issue_data1 <= '0;
            end
         end
      end
   end

   assert_busy_no_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && wr_stb) |=> !(issue_word || issue_pair || issue_erase));

   assert_issue_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_word, issue_pair, issue_erase}));

   assert_bad_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_ERS_CONFIRM && wr_stb && op != ERASE_CONFIRM)
      |=> (erase_err && prog_err && mode == RM_ARRAY && !issue_erase));

   assert_pair_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_PAIR_SECOND && wr_stb && wr_addr[ADDR_W-1:1] != first_addr_q[ADDR_W-1:1])
      |=> (!issue_pair && prog_err));

endmodule

// File: rtl/fcs_rdmux.sv
module fcs_rdmux
   import fcs_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  MFR_CODE = 8'h5A,
   parameter logic [7:0]  DEV_CODE = 8'hC3
)(
   input  rd_mode_e          sel,
   input  logic              rd_lsb,
   input  logic [7:0]        status,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [DATA_W-1:0] qry_data,
   output logic [DATA_W-1:0] rd_data
);

   always_comb begin
      case (sel)
         RM_STATUS: rd_data = {{(DATA_W-8){1'b0}}, status};
         RM_IDENT:  rd_data = {{(DATA_W-8){1'b0}}, (rd_lsb ? DEV_CODE : MFR_CODE)};
         RM_QUERY:  rd_data = qry_data;
         default:   rd_data = arr_data;
      endcase
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int unsigned ADDR_W       = 19,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned WORD_CYCLES  = 12,
   parameter int unsigned ERASE_CYCLES = 40,
   parameter bit          PAIR_EN      = 1'b1,
   parameter logic [7:0]  MFR_CODE     = 8'h5A,
   parameter logic [7:0]  DEV_CODE     = 8'hC3,
   parameter logic [7:0]  OP_ARRAY     = 8'hFF,
   parameter logic [7:0]  OP_STATUS    = 8'h70,
   parameter logic [7:0]  OP_IDENT     = 8'h90,
   parameter logic [7:0]  OP_QUERY     = 8'h98,
   parameter logic [7:0]  OP_CLEAR     = 8'h50,
   parameter logic [7:0]  OP_ERASE     = 8'h20,
   parameter logic [7:0]  OP_WORD      = 8'h40,
   parameter logic [7:0]  OP_PAIR      = 8'h30,
   parameter logic [7:0]  OP_SUSPEND   = 8'hB0,
   parameter logic [7:0]  OP_RESUME    = 8'hD0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_lsb,
   input  logic [DATA_W-1:0] arr_data,
   input  logic [DATA_W-1:0] qry_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_mode,
   output logic              issue_word,
   output logic              issue_pair,
   output logic              issue_erase,
   output logic [ADDR_W-1:0] issue_addr,
   output logic [DATA_W-1:0] issue_data0,
   output logic [DATA_W-1:0] issue_data1,
   output logic              eng_busy,
   output logic              eng_done
);

   localparam logic [79:0] OPS_PACKED = {OP_ARRAY, OP_STATUS, OP_IDENT, OP_QUERY, OP_CLEAR,
                                         OP_ERASE, OP_WORD, OP_PAIR, OP_SUSPEND, OP_RESUME};

   generate
      if (WORD_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_cycles
         $error("flash_cmd_seq: operation lengths must be at least one cycle");
      end
      if (DATA_W < 16 || ADDR_W < 2) begin : g_bad_width
         $error("flash_cmd_seq: DATA_W must be >= 16 and ADDR_W >= 2");
      end
      if (!fcs_ops_distinct(OPS_PACKED)) begin : g_bad_ops
         $error("flash_cmd_seq: opcodes must be pairwise distinct");
      end
   endgenerate

   rd_mode_e mode, eff_mode;
   op_kind_e start_kind;
   logic     prog_err, erase_err;
   logic     start_vld, nest_vld, susp_req, resume_req;
   logic     susp_erase, susp_word, nested;
   logic [7:0] status;

   fcs_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAIR_EN(PAIR_EN),
      .OP_ARRAY(OP_ARRAY), .OP_STATUS(OP_STATUS), .OP_IDENT(OP_IDENT),
      .OP_QUERY(OP_QUERY), .OP_CLEAR(OP_CLEAR), .OP_ERASE(OP_ERASE),
      .OP_WORD(OP_WORD), .OP_PAIR(OP_PAIR), .OP_SUSPEND(OP_SUSPEND),
      .OP_RESUME(OP_RESUME)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_busy(eng_busy), .eng_susp_erase(susp_erase), .eng_susp_word(susp_word),
      .eng_nested(nested),
      .mode(mode), .prog_err(prog_err), .erase_err(erase_err),
      .start_vld(start_vld), .start_kind(start_kind), .nest_vld(nest_vld),
      .susp_req(susp_req), .resume_req(resume_req),
      .issue_word(issue_word), .issue_pair(issue_pair), .issue_erase(issue_erase),
      .issue_addr(issue_addr), .issue_data0(issue_data0), .issue_data1(issue_data1)
   );

   fcs_engine #(
      .WORD_CYCLES(WORD_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .start_vld(start_vld), .start_kind(start_kind), .nest_vld(nest_vld),
      .susp_req(susp_req), .resume_req(resume_req),
      .busy(eng_busy), .susp_erase(susp_erase), .susp_word(susp_word),
      .nested(nested), .done(eng_done)
   );

   always_comb begin
      status             = 8'h00;
      status[SB_READY]   = !eng_busy;
      status[SB_ERS_SUS] = susp_erase;
      status[SB_ERS_ERR] = erase_err;
      status[SB_PGM_ERR] = prog_err;
      status[SB_PGM_SUS] = susp_word;
   end

   assign eff_mode = eng_busy ? RM_STATUS : mode;
   assign rd_mode  = eff_mode;

   fcs_rdmux #(
      .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
   ) u_rdmux (
      .sel(eff_mode), .rd_lsb(rd_lsb), .status(status),
      .arr_data(arr_data), .qry_data(qry_data), .rd_data(rd_data)
   );

   assert_issue_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_word || issue_pair || issue_erase) |-> eng_busy);

   assert_pause_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) && !eng_done |-> (susp_erase || susp_word));

   assert_resume_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resume_req |=> (rd_mode == 2'd1));

endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;

   localparam int AW = 19;
   localparam int DW = 16;
   localparam int WORD_CYC = 12;
   localparam int ERASE_CYC = 40;
   localparam logic [7:0] MFR = 8'h5A;
   localparam logic [7:0] DEV = 8'hC3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_stb = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_lsb = 1'b0;
   logic [DW-1:0] arr_data, qry_data, rd_data;
   logic [1:0]    rd_mode;
   logic          issue_word, issue_pair, issue_erase, eng_busy, eng_done;
   logic [AW-1:0] issue_addr;
   logic [DW-1:0] issue_data0, issue_data1;

   int checks = 0;
   int errors = 0;
   int busy_seen = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   assign arr_data = 16'hA5A5 ^ {15'd0, rd_lsb};
   assign qry_data = 16'h3C51 ^ {15'd0, rd_lsb};

   flash_cmd_seq #(
      .ADDR_W(AW), .DATA_W(DW), .WORD_CYCLES(WORD_CYC), .ERASE_CYCLES(ERASE_CYC),
      .MFR_CODE(MFR), .DEV_CODE(DEV)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_lsb(rd_lsb), .arr_data(arr_data), .qry_data(qry_data), .rd_data(rd_data),
      .rd_mode(rd_mode), .issue_word(issue_word), .issue_pair(issue_pair),
      .issue_erase(issue_erase), .issue_addr(issue_addr), .issue_data0(issue_data0),
      .issue_data1(issue_data1), .eng_busy(eng_busy), .eng_done(eng_done)
   );

   always @(negedge clk) if (eng_busy) busy_seen++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic bwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
      tick();
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_stb = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000; i++) begin
         if (!eng_busy) break;
         tick();
      end
   endtask

   task automatic chk_status(input string req, input logic [7:0] exp);
      chk(rd_data == {8'h00, exp}, req, rd_data, {8'h00, exp});
   endtask

   function automatic logic [1:0] model_mode(input logic [1:0] cur, input logic [7:0] op);
      case (op)
         8'hFF:   return 2'd0;
         8'h70:   return 2'd1;
         8'h90:   return 2'd2;
         8'h98:   return 2'd3;
         8'h50:   return cur;
         default: return 2'd0;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int snap;
      logic [1:0] cur;
      void'($urandom(32'd4242));
      repeat (3) tick();
      // R1 reset state
      chk(rd_mode == 2'd0, "R1 mode", rd_mode, 0);
      chk(eng_busy == 1'b0, "R1 busy", eng_busy, 0);
      chk(rd_data == arr_data, "R1 array data", rd_data, arr_data);
      rst_n = 1'b1;
      tick();
      bwrite('0, 16'h0070);
      chk_status("R1 status", 8'h80);

      // R2 / R3 read sources
      bwrite('0, 16'h0090);
      rd_lsb = 1'b0; #1;
      chk(rd_data == {8'h00, MFR}, "R3 mfr", rd_data, {8'h00, MFR});
      rd_lsb = 1'b1; #1;
      chk(rd_data == {8'h00, DEV}, "R3 dev", rd_data, {8'h00, DEV});
      chk(rd_mode == 2'd2, "R2 ident mode", rd_mode, 2);
      bwrite('0, 16'h0098);
      chk(rd_mode == 2'd3 && rd_data == qry_data, "R2 query", rd_data, qry_data);
      bwrite('0, 16'h0012);
      chk(rd_mode == 2'd0, "R2 invalid to array", rd_mode, 0);

      // R4 word program
      snap = busy_seen;
      bwrite('0, 16'h0040);
      bwrite(19'h12345, 16'hBEEF);
      chk(issue_word && issue_addr == 19'h12345 && issue_data0 == 16'hBEEF,
          "R4 issue", issue_data0, 16'hBEEF);
      chk_status("R4 busy status", 8'h00);
      // R7 ignored while busy
      bwrite('0, 16'h00FF);
      chk(rd_mode == 2'd1, "R7 busy read source", rd_mode, 1);
      bwrite('0, 16'h0040);
      chk(!issue_word, "R7 no restart", issue_word, 0);
      wait_idle();
      chk(busy_seen - snap == WORD_CYC, "R4 busy length", busy_seen - snap, WORD_CYC);
      chk(rd_mode == 2'd1, "R7 FF dropped", rd_mode, 1);
      chk_status("R4 done status", 8'h80);

      // R5 bad confirm, then clear
      bwrite(19'h40000, 16'h0020);
      bwrite(19'h40000, 16'h0055);
      chk(!issue_erase && rd_mode == 2'd0, "R5 bad confirm", rd_mode, 0);
      bwrite('0, 16'h0070);
      chk_status("R5 error bits", 8'hB0);
      bwrite('0, 16'h0050);
      chk(rd_mode == 2'd1, "R2 clear keeps mode", rd_mode, 1);
      chk_status("R2 clear", 8'h80);

      // R8/R9 erase, pause, nested program, resume
      snap = busy_seen;
      bwrite('0, 16'h0020);
      bwrite(19'h48000, 16'h00D0);
      chk(issue_erase && issue_addr == 19'h48000, "R5 erase issue", issue_addr, 19'h48000);
      repeat (3) tick();
      bwrite('0, 16'h00B0);
      chk(!eng_busy, "R8 paused", eng_busy, 0);
      chk_status("R8 erase paused", 8'hC0);
      bwrite('0, 16'h0030);
      bwrite('0, 16'h0020);
      chk(rd_mode == 2'd1 && !issue_erase, "R9 dropped", rd_mode, 1);
      bwrite('0, 16'h0090);
      chk(rd_mode == 2'd2, "R9 ident in pause", rd_mode, 2);
      bwrite('0, 16'h0040);
      bwrite(19'h00010, 16'h1234);
      chk(issue_word && eng_busy, "R9 nested issue", issue_word, 1);
      wait_idle();
      chk_status("R9 back to paused", 8'hC0);
      bwrite('0, 16'h00D0);
      chk(eng_busy && rd_mode == 2'd1, "R8 resume", eng_busy, 1);
      wait_idle();
      chk(busy_seen - snap == ERASE_CYC + WORD_CYC, "R8 total busy",
          busy_seen - snap, ERASE_CYC + WORD_CYC);
      chk_status("R8 erase done", 8'h80);

      // R8/R9 program pause rejects program
      snap = busy_seen;
      bwrite('0, 16'h0040);
      bwrite(19'h00020, 16'h0F0F);
      bwrite('0, 16'h00B0);
      chk_status("R8 program paused", 8'h84);
      bwrite('0, 16'h0040);
      chk(rd_mode == 2'd1, "R9 program refused", rd_mode, 1);
      bwrite(19'h00021, 16'h5555);
      chk(!issue_word && !eng_busy, "R9 no nested", issue_word, 0);
      bwrite('0, 16'h00FF);
      chk(rd_mode == 2'd0 && rd_data == arr_data, "R9 array in pause", rd_mode, 0);
      bwrite('0, 16'h00D0);
      chk(eng_busy && rd_mode == 2'd1, "R8 program resume", rd_mode, 1);
      wait_idle();
      chk(busy_seen - snap == WORD_CYC, "R8 program total", busy_seen - snap, WORD_CYC);

      // R6 paired program
      bwrite('0, 16'h0030);
      bwrite(19'h00100, 16'hAAAA);
      bwrite(19'h00101, 16'h5555);
      chk(issue_pair && issue_addr == 19'h00100 && issue_data0 == 16'hAAAA &&
          issue_data1 == 16'h5555, "R6 pair issue", issue_data1, 16'h5555);
      wait_idle();
      bwrite('0, 16'h0030);
      bwrite(19'h00100, 16'h1111);
      bwrite(19'h00203, 16'h2222);
      chk(!issue_pair && rd_mode == 2'd0, "R6 bad pair", rd_mode, 0);
      bwrite('0, 16'h0070);
      chk_status("R6 error bit", 8'h90);

      // R10 reset during erase
      bwrite('0, 16'h0020);
      bwrite('0, 16'h00D0);
      repeat (2) tick();
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      chk(!eng_busy && rd_mode == 2'd0, "R10 abort", rd_mode, 0);
      bwrite('0, 16'h0070);
      chk_status("R10 cleared", 8'h80);

      // R2 random single-cycle opcodes
      bwrite('0, 16'h00FF);
      cur = 2'd0;
      for (int i = 0; i < 40; i++) begin
         logic [7:0] op;
         op = 8'($urandom_range(0, 255));
         if (op == 8'h20 || op == 8'h30 || op == 8'h40) op = 8'h98;
         if (i % 4 == 0) op = (i % 8 == 0) ? 8'h70 : 8'h50;
         bwrite('0, {8'h00, op});
         cur = model_mode(cur, op);
         chk(rd_mode == cur && !eng_busy, "R2 random op", rd_mode, cur);
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule